// File: doc/BRIEF.md
# Program Counter and Subroutine Return Stack

This block keeps the instruction address of a small 8-bit controller and the hardware stack of return addresses used by subroutine calls and interrupts. On every cycle in which the sequencer asserts a step, the block moves the 10-bit counter to one of four places: the next address, an absolute target given with the instruction, an address popped from the return stack, or the interrupt vector at the top of the code space. Jumps, calls and returns can be unconditional or tied to the state of the ZERO or CARRY flag.

The block also owns the ZERO and CARRY flags and the interrupt-enable flag. When it accepts an interrupt, it saves both flags and disables further interrupts. A return from interrupt restores the saved flags and sets interrupt-enable from a one-bit operand. The return stack is a ring of 31 entries. When it is full, the oldest entry is overwritten. Software cannot see its pointer, and no error is raised when the stack overflows or underflows. Instruction decode, program memory and the ALU are outside the block. The ALU hands in new flag values through a write strobe.

Top module: `pc_retstack`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, pc_o is 000 and zero_o, carry_o and ie_o are 0. The stack is emptied and every slot is cleared, so a return executed before any push resumes at 000.
- R2: A step with br_kind_i = 000 (sequential), or with any unused kind code 101..111, loads pc_o + 1 into the counter. From 3FF the counter wraps to 000.
- R3: While step_i is low, pc_o, the flags and the stack do not change, whatever the other inputs are.
- R4: br_kind_i = 001 is a jump and loads target_i when the condition passes. The cond_i codes are: 100 passes on ZERO set, 101 on ZERO clear, 110 on CARRY set, 111 on CARRY clear, and any other code always passes.
- R5: A jump, call or return (kinds 001, 010, 011) whose condition fails only advances the counter by one. The stack is left unchanged.
- R6: br_kind_i = 010 is a call. When its condition passes, it pushes pc_o + 1 and loads target_i. br_kind_i = 011 is a return. When its condition passes, it pops an address and loads it unchanged.
- R7: The stack holds the 31 most recent pushes. A 32nd push overwrites the oldest entry, and returns then deliver the newer entries in last-in, first-out order.
- R8: A step with irq_i high while ie_o is 1 ignores the branch inputs and the flag and enable writes. It pushes pc_o, loads 3FF, saves ZERO and CARRY, and clears ie_o. When ie_o is 0, irq_i has no effect.
- R9: br_kind_i = 100 is a return from interrupt and ignores cond_i. It pops an address and loads it unchanged, restores ZERO and CARRY from the last saved pair, and sets ie_o to reti_ie_i.
- R10: On a step with no interrupt taken and no return from interrupt, flag_we_i loads zero_i and carry_i into the flags, and ie_we_i loads ie_val_i into ie_o.
- R11: A pop on an empty stack returns the slot that the pointer wraps to, and the stack keeps working afterwards with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | One instruction step completes this cycle |
| br_kind_i | input | 3 | Kind of flow change: 000 sequential, 001 jump, 010 call, 011 return, 100 return from interrupt |
| cond_i | input | 3 | Condition code, see R4 |
| target_i | input | 10 | Absolute jump or call target |
| irq_i | input | 1 | Interrupt request, taken on a step while ie_o is 1 |
| reti_ie_i | input | 1 | Interrupt-enable value applied by a return from interrupt |
| flag_we_i | input | 1 | Load zero_i and carry_i into the flags on this step |
| zero_i | input | 1 | New ZERO value from the ALU |
| carry_i | input | 1 | New CARRY value from the ALU |
| ie_we_i | input | 1 | Load ie_val_i into the interrupt-enable flag on this step |
| ie_val_i | input | 1 | New interrupt-enable value |
| pc_o | output | 10 | Address of the current instruction |
| zero_o | output | 1 | ZERO flag |
| carry_o | output | 1 | CARRY flag |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The stack pointer and the stack slots are visible only through pc_o. A wrong slot, a wrong pointer step or an off-by-one in the ring size therefore shows up only when a return loads a wrong address. That can happen many cycles after the faulty push. For this reason the stimulus nests calls past the 31-entry limit, unwinds them fully, and then pops past the bottom. A lost or stale saved flag pair shows on zero_o and carry_o in the cycle right after a return from interrupt. A wrong condition decode or a wrong priority shows on pc_o one cycle after the offending step. The reference model is compared against the design on every clock, so each of these faults is caught on the first cycle it reaches an output.

// File: rtl/pcs_pkg.sv
// Shared types for the program counter and return stack.
// Assumes: 3-bit kind and condition codes as described in the brief.
package pcs_pkg;
    typedef enum logic [2:0] {
        BR_SEQ  = 3'b000,
        BR_JUMP = 3'b001,
        BR_CALL = 3'b010,
        BR_RET  = 3'b011,
        BR_RETI = 3'b100
    } br_kind_e;

    localparam logic [2:0] CC_ZSET = 3'b100;
    localparam logic [2:0] CC_ZCLR = 3'b101;
    localparam logic [2:0] CC_CSET = 3'b110;
    localparam logic [2:0] CC_CCLR = 3'b111;
endpackage

// File: rtl/pcs_cond_eval.sv
// Evaluates a branch condition code against the ZERO and CARRY flags.
// Assumes: any code other than the four flag tests means "always".
module pcs_cond_eval
    import pcs_pkg::*;
(
    input  logic [2:0] cond_i,
    input  logic       zero_i,
    input  logic       carry_i,
    output logic       pass_o
);
    // Decode the condition into a single pass bit.
    always_comb begin
        case (cond_i)
            CC_ZSET: pass_o = zero_i;
            CC_ZCLR: pass_o = ~zero_i;
            CC_CSET: pass_o = carry_i;
            CC_CCLR: pass_o = ~carry_i;
            default: pass_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pcs_ret_stack.sv
// Ring of DEPTH return addresses with a hidden top pointer.
// Push writes the slot after the top; pop reads the top and steps back.
// Assumes: push and pop are never asserted together. Overflow overwrites,
// underflow wraps, neither is reported.
module pcs_ret_stack #(
    parameter int DEPTH = 31,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    output logic [AW-1:0] top_addr_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] top_q;
    logic [PW-1:0] nxt_slot;
    logic [PW-1:0] prv_slot;
    logic [AW-1:0] slot_q [DEPTH];

    assign nxt_slot   = (top_q == LAST) ? '0 : top_q + 1'b1;
    assign prv_slot   = (top_q == '0) ? LAST : top_q - 1'b1;
    assign top_addr_o = slot_q[top_q];

    // Move the top pointer around the ring on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      top_q <= '0;
        else if (push_i) top_q <= nxt_slot;
        else if (pop_i)  top_q <= prv_slot;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Hold one return address; written when a push lands on this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                slot_q[g] <= '0;
            else if (push_i && nxt_slot == PW'(g))     slot_q[g] <= push_addr_i;
        end
    end
endmodule

// File: rtl/pcs_flag_unit.sv
// Holds ZERO, CARRY, interrupt-enable and the flag pair saved on interrupt.
// Assumes: the strobes arrive already qualified by step and priority.
module pcs_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_take_i,
    input  logic reti_i,
    input  logic reti_ie_i,
    input  logic flag_we_i,
    input  logic zero_i,
    input  logic carry_i,
    input  logic ie_we_i,
    input  logic ie_val_i,
    output logic zero_o,
    output logic carry_o,
    output logic ie_o
);
    logic sv_zero_q;
    logic sv_carry_q;

    // Update the live flags from the ALU or restore them on interrupt return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_o  <= 1'b0;
            carry_o <= 1'b0;
        end else if (reti_i) begin
            zero_o  <= sv_zero_q;
            carry_o <= sv_carry_q;
        end else if (flag_we_i) begin
            zero_o  <= zero_i;
            carry_o <= carry_i;
        end
    end

    // Capture the live flags when an interrupt is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_zero_q  <= 1'b0;
            sv_carry_q <= 1'b0;
        end else if (irq_take_i) begin
            sv_zero_q  <= zero_o;
            sv_carry_q <= carry_o;
        end
    end

    // Track interrupt-enable: cleared on accept, set by return or write.
    always_ff @(posedge clk) begin
        if (!rst_n)          ie_o <= 1'b0;
        else if (irq_take_i) ie_o <= 1'b0;
        else if (reti_i)     ie_o <= reti_ie_i;
        else if (ie_we_i)    ie_o <= ie_val_i;
    end
endmodule

// File: rtl/pc_retstack.sv
// Program counter with conditional flow control and a cyclic return stack.
// Assumes: step_i marks the cycle an instruction at pc_o completes; an
// accepted interrupt preempts that instruction entirely.
module pc_retstack
    import pcs_pkg::*;
#(
    parameter int PC_W      = 10,
    parameter int STK_DEPTH = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [2:0]      br_kind_i,
    input  logic [2:0]      cond_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            irq_i,
    input  logic            reti_ie_i,
    input  logic            flag_we_i,
    input  logic            zero_i,
    input  logic            carry_i,
    input  logic            ie_we_i,
    input  logic            ie_val_i,
    output logic [PC_W-1:0] pc_o,
    output logic            zero_o,
    output logic            carry_o,
    output logic            ie_o
);
    localparam logic [PC_W-1:0] VECTOR = '1;

    br_kind_e        kind;
    logic            cond_ok;
    logic            irq_take;
    logic            norm;
    logic            do_jump, do_call, do_ret, do_reti;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] pc_nxt;

    assign kind     = br_kind_e'(br_kind_i);
    assign pc_inc   = pc_o + 1'b1;
    assign irq_take = step_i & irq_i & ie_o;
    assign norm     = step_i & ~irq_take;
    assign do_jump  = norm & (kind == BR_JUMP) & cond_ok;
    assign do_call  = norm & (kind == BR_CALL) & cond_ok;
    assign do_ret   = norm & (kind == BR_RET)  & cond_ok;
    assign do_reti  = norm & (kind == BR_RETI);

    pcs_cond_eval u_cond (
        .cond_i  (cond_i),
        .zero_i  (zero_o),
        .carry_i (carry_o),
        .pass_o  (cond_ok)
    );

    pcs_ret_stack #(.DEPTH(STK_DEPTH), .AW(PC_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (irq_take | do_call),
        .pop_i       (do_ret | do_reti),
        .push_addr_i (irq_take ? pc_o : pc_inc),
        .top_addr_o  (stk_top)
    );

    pcs_flag_unit u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_take_i (irq_take),
        .reti_i     (do_reti),
        .reti_ie_i  (reti_ie_i),
        .flag_we_i  (norm & ~do_reti & flag_we_i),
        .zero_i     (zero_i),
        .carry_i    (carry_i),
        .ie_we_i    (norm & ~do_reti & ie_we_i),
        .ie_val_i   (ie_val_i),
        .zero_o     (zero_o),
        .carry_o    (carry_o),
        .ie_o       (ie_o)
    );

    // Select the next address: vector, target, popped address or increment.
    always_comb begin
        if (irq_take)                 pc_nxt = VECTOR;
        else if (do_jump || do_call)  pc_nxt = target_i;
        else if (do_ret || do_reti)   pc_nxt = stk_top;
        else                          pc_nxt = pc_inc;
    end

    // Hold the counter; advance it only on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_o <= '0;
        else if (step_i) pc_o <= pc_nxt;
    end
endmodule

// File: rtl/pc_retstack_chk.sv
// Port-level temporal checks for pc_retstack, attached by bind.
// Assumes: encodings from the brief; looks at ports only.
module pc_retstack_chk #(
    parameter int PC_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_i,
    input logic [2:0]      br_kind_i,
    input logic [2:0]      cond_i,
    input logic [PC_W-1:0] target_i,
    input logic            irq_i,
    input logic            reti_ie_i,
    input logic [PC_W-1:0] pc_o,
    input logic            zero_o,
    input logic            carry_o,
    input logic            ie_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && !zero_o && !carry_o && !ie_o));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pc_o) && $stable(zero_o) && $stable(carry_o) && $stable(ie_o)));

    p_seq_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !(irq_i && ie_o) && br_kind_i == 3'b000)
        |=> pc_o == PC_W'($past(pc_o) + 1'b1));

    p_jump_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !(irq_i && ie_o) && br_kind_i == 3'b001 && cond_i == 3'b000)
        |=> pc_o == $past(target_i));

    p_irq_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && irq_i && ie_o) |=> (pc_o == '1 && !ie_o));

    p_reti_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !(irq_i && ie_o) && br_kind_i == 3'b100)
        |=> ie_o == $past(reti_ie_i));
endmodule

bind pc_retstack pc_retstack_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_i),
    .br_kind_i (br_kind_i),
    .cond_i    (cond_i),
    .target_i  (target_i),
    .irq_i     (irq_i),
    .reti_ie_i (reti_ie_i),
    .pc_o      (pc_o),
    .zero_o    (zero_o),
    .carry_o   (carry_o),
    .ie_o      (ie_o)
);

// File: tb/pc_retstack_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module pc_retstack_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic [2:0] br_kind_i = '0;
    logic [2:0] cond_i = '0;
    logic [9:0] target_i = '0;
    logic       irq_i = 1'b0;
    logic       reti_ie_i = 1'b0;
    logic       flag_we_i = 1'b0;
    logic       zero_i = 1'b0;
    logic       carry_i = 1'b0;
    logic       ie_we_i = 1'b0;
    logic       ie_val_i = 1'b0;
    logic [9:0] pc_o;
    logic       zero_o, carry_o, ie_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_retstack u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_kind_i(br_kind_i),
        .cond_i(cond_i), .target_i(target_i), .irq_i(irq_i), .reti_ie_i(reti_ie_i),
        .flag_we_i(flag_we_i), .zero_i(zero_i), .carry_i(carry_i),
        .ie_we_i(ie_we_i), .ie_val_i(ie_val_i),
        .pc_o(pc_o), .zero_o(zero_o), .carry_o(carry_o), .ie_o(ie_o)
    );

    // Reference model state
    int m_pc;
    bit m_z, m_c, m_ie, m_sz, m_sc;
    int m_ring [DEPTH];
    int m_top;

    function automatic bit cond_pass(input logic [2:0] cc, input bit z, input bit c);
        if (cc == 3'b100) return z;
        if (cc == 3'b101) return !z;
        if (cc == 3'b110) return c;
        if (cc == 3'b111) return !c;
        return 1'b1;
    endfunction

    function automatic int ring_pop();
        int v;
        v = m_ring[m_top];
        m_top = (m_top == 0) ? DEPTH - 1 : m_top - 1;
        return v;
    endfunction

    task automatic ring_push(input int v);
        m_top = (m_top + 1) % DEPTH;
        m_ring[m_top] = v;
    endtask

    // Advance the model on each rising edge from the inputs held since the last falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_z = 0; m_c = 0; m_ie = 0; m_sz = 0; m_sc = 0; m_top = 0;
            for (int i = 0; i < DEPTH; i++) m_ring[i] = 0;
        end else if (step_i) begin
            if (irq_i && m_ie) begin
                ring_push(m_pc);
                m_pc = 10'h3FF; m_sz = m_z; m_sc = m_c; m_ie = 0;
            end else if (br_kind_i == 3'b100) begin
                m_pc = ring_pop();
                m_z = m_sz; m_c = m_sc; m_ie = reti_ie_i;
            end else begin
                bit ok;
                int nxt;
                ok  = cond_pass(cond_i, m_z, m_c);
                nxt = (m_pc + 1) % 1024;
                if (br_kind_i == 3'b001 && ok) nxt = target_i;
                else if (br_kind_i == 3'b010 && ok) begin ring_push((m_pc + 1) % 1024); nxt = target_i; end
                else if (br_kind_i == 3'b011 && ok) nxt = ring_pop();
                m_pc = nxt;
                if (flag_we_i) begin m_z = zero_i; m_c = carry_i; end
                if (ie_we_i) m_ie = ie_val_i;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (pc_o !== 10'(m_pc) || zero_o !== m_z || carry_o !== m_c || ie_o !== m_ie) begin
            n_bad++;
            $display("FAIL %s: pc/z/c/ie actual %h/%b/%b/%b expected %h/%b/%b/%b",
                     cur_req, pc_o, zero_o, carry_o, ie_o, 10'(m_pc), m_z, m_c, m_ie);
        end
    endtask

    task automatic clr_in();
        step_i = 0; br_kind_i = 0; cond_i = 0; target_i = 0; irq_i = 0;
        reti_ie_i = 0; flag_we_i = 0; zero_i = 0; carry_i = 0; ie_we_i = 0; ie_val_i = 0;
    endtask

    // One step with the given flow change, then compare after the edge.
    task automatic op(input logic [2:0] k, input logic [2:0] cc, input int tgt);
        clr_in();
        step_i = 1; br_kind_i = k; cond_i = cc; target_i = 10'(tgt);
        @(negedge clk); compare();
    endtask

    task automatic set_flags(input bit z, input bit c);
        clr_in(); step_i = 1; flag_we_i = 1; zero_i = z; carry_i = c;
        @(negedge clk); compare();
    endtask

    task automatic set_ie(input bit v);
        clr_in(); step_i = 1; ie_we_i = 1; ie_val_i = v;
        @(negedge clk); compare();
    endtask

    task automatic irq_step(input logic [2:0] k, input int tgt);
        clr_in(); step_i = 1; irq_i = 1; br_kind_i = k; target_i = 10'(tgt);
        flag_we_i = 1; zero_i = 1; carry_i = 1; ie_we_i = 1; ie_val_i = 1;
        @(negedge clk); compare();
    endtask

    task automatic reti(input bit ie);
        clr_in(); step_i = 1; br_kind_i = 3'b100; cond_i = 3'b100; reti_ie_i = ie;
        @(negedge clk); compare();
    endtask

    task automatic do_reset();
        cur_req = "R1";
        clr_in(); rst_n = 0;
        @(negedge clk); compare();
        @(negedge clk); compare();
        rst_n = 1;
        @(negedge clk); compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

    initial begin
        clr_in();
        @(negedge clk);
        do_reset();
        // R1: return right after reset resumes at 000
        cur_req = "R1"; op(3'b000, 0, 0); op(3'b011, 0, 0);

        // R2: increments, unused kind codes, wrap at top
        cur_req = "R2";
        for (int i = 0; i < 4; i++) op(3'b000, 0, 0);
        op(3'b101, 0, 0); op(3'b111, 0, 0);
        op(3'b001, 0, 10'h3FD);
        for (int i = 0; i < 4; i++) op(3'b000, 0, 0);

        // R3: step low with every other input active
        cur_req = "R3";
        for (int i = 0; i < 5; i++) begin
            clr_in(); br_kind_i = 3'b010; target_i = 10'h155; irq_i = 1;
            flag_we_i = 1; zero_i = 1; carry_i = 1; ie_we_i = 1; ie_val_i = 1;
            @(negedge clk); compare();
        end

        // R10: flag and enable writes
        cur_req = "R10";
        set_flags(1, 0); set_flags(0, 1); set_flags(1, 1); set_ie(1); set_ie(0);

        // R4 and R5: each condition code, true and false
        for (int f = 0; f < 4; f++) begin
            set_flags(f[0], f[1]);
            for (int cc = 0; cc < 8; cc++) begin
                cur_req = "R4"; op(3'b001, 3'(cc), 10'h040 + cc * 8 + f);
                cur_req = "R5"; op(3'b010, 3'(cc), 10'h200 + cc);
                op(3'b011, 3'(cc), 0);
            end
        end

        // R6: nested calls and returns
        do_reset();
        cur_req = "R6";
        op(3'b010, 0, 10'h100); op(3'b000, 0, 0); op(3'b010, 0, 10'h180);
        op(3'b010, 0, 10'h1C0); op(3'b011, 0, 0); op(3'b011, 0, 0);
        op(3'b000, 0, 0); op(3'b011, 0, 0);

        // R7: overflow the ring, then unwind; R11: pop past empty
        cur_req = "R7";
        for (int i = 0; i < DEPTH + 3; i++) op(3'b010, 0, 10'h010 + i * 5);
        for (int i = 0; i < DEPTH; i++) op(3'b011, 0, 0);
        cur_req = "R11";
        for (int i = 0; i < 5; i++) op(3'b011, 0, 0);
        op(3'b010, 0, 10'h2A0); op(3'b011, 0, 0);

        // R8: interrupt ignored while disabled, then taken
        cur_req = "R8";
        set_flags(1, 0);
        irq_step(3'b001, 10'h0AA);
        set_ie(1);
        irq_step(3'b010, 10'h0BB);
        op(3'b000, 0, 0);
        set_flags(0, 1);
        irq_step(3'b000, 0);
        // R9: return from interrupt restores flags and sets enable
        cur_req = "R9";
        reti(1);
        set_flags(0, 0);
        reti(0);
        op(3'b000, 0, 0);

        // Mixed traffic
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            clr_in();
            step_i    = ($urandom % 8) != 0;
            br_kind_i = 3'($urandom % 6);
            cond_i    = 3'($urandom);
            target_i  = 10'($urandom);
            irq_i     = ($urandom % 6) == 0;
            reti_ie_i = 1'($urandom);
            flag_we_i = 1'($urandom);
            zero_i    = 1'($urandom);
            carry_i   = 1'($urandom);
            ie_we_i   = ($urandom % 4) == 0;
            ie_val_i  = 1'($urandom);
            @(negedge clk); compare();
        end

        do_reset();
        finish_run();
    end
endmodule